// File: doc/BRIEF.md
# Upstream Bus-Reset Detection and High-Speed Handshake Controller

This block watches the line state of a hub's upstream port to tell a host-issued bus reset apart from ordinary traffic. Once the reset is confirmed, it runs the speed handshake. How long the line must hold SE0 before the block acts depends on what the port was doing when SE0 began. A suspended port acts after a short filter time. A full-speed port waits a few microseconds. A high-speed port first waits about three milliseconds. It then drops back to full-speed terminations, waits again, and samples the line once to decide whether the SE0 really is a reset.

When the block accepts a reset, it drives a timed chirp K toward the host. It then listens for an alternating sequence of host chirps, each of which must stay stable for a filter time. If enough of them arrive before the fallback timer runs out, it selects high-speed terminations. Otherwise it settles on full speed. All time is counted on an external one-microsecond tick, and every limit is a parameter in tick units.

Top module: `ushs_reset_nego`

## Requirements
- R1: While reset is asserted, all outputs are low. While idle, `hs_term` follows `cur_hs` one clock later.
- R2: When `suspended` is high, SE0 held for FILT_US (3) ticks starts the handshake. This applies whatever the value of `cur_hs`.
- R3: When the port is not suspended and `cur_hs` is low, SE0 held for FS_WAIT_US (10) ticks starts the handshake.
- R4: When the port is not suspended and `cur_hs` is high, SE0 held for REVERT_US (3000) ticks drops `hs_term`. POSTREV_US (500) ticks later the line is sampled once. If it shows SE0, the handshake starts. Any other value returns the block to idle with no reset. Line activity during the wait has no effect.
- R5: If SE0 ends before the threshold that applies, there is no reset pulse and no chirp, and the SE0 timer restarts.
- R6: `chirp_k` stays high for exactly CHIRP_US (2000) ticks. `hs_term` is low throughout.
- R7: After the chirp, the block looks for host chirps in the order K, J, K, J and so on. A chirp counts only when the line holds the expected state for FILT_US consecutive ticks, and a leading J is not counted. Once HOST_CHIRPS (6) have been counted, the block raises `hs_term`, sets `nego_hs` to 1 and pulses `nego_valid`.
- R8: If the full host sequence has not arrived within FALLBACK_US (2000) ticks after the chirp ends, the block pulses `nego_valid` with `nego_hs` equal to 0, and `hs_term` is low.
- R9: `reset_pulse` lasts one clock and rises in the same cycle that `chirp_k` rises.
- R10: Timers advance only on clocks where `us_tick` is high.
- R11: Line state encoding is 00 for SE0, 01 for J, 10 for K and 11 for SE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle strobe, once per microsecond |
| line_state | input | 2 | Upstream line state (00 SE0, 01 J, 10 K, 11 SE1) |
| cur_hs | input | 1 | Port currently operating at high speed |
| suspended | input | 1 | Port currently suspended |
| chirp_k | output | 1 | Drive chirp K upstream |
| hs_term | output | 1 | 1 selects high-speed terminations, 0 full-speed |
| reset_pulse | output | 1 | One-cycle bus-reset-detected strobe |
| nego_hs | output | 1 | Result of the last negotiation (1 = high speed) |
| nego_valid | output | 1 | One-cycle strobe when `nego_hs` is updated |

## Verification
The bench holds SE0 for one tick less than each threshold to catch an off-by-one that would issue a false reset. It also gives a suspended port `cur_hs` high, so a wrong priority would show up as a 3000-tick revert in place of a 3-tick filter. In the revert path it toggles the line in the middle of the wait, which a design that samples continuously would treat as an abort. It also releases SE0 before the sampling point, which a design that ignores the sample would turn into a spurious reset. On the host side, the bench sends five chirps, a sequence that starts with J, and chirps shorter than the filter time. A loose counter or filter would accept high speed in each of these cases.

// File: rtl/ushs_pkg.sv
// Package: shared encodings for the upstream reset/speed negotiation block.
// Assumes a 2-bit line-state code supplied by the transceiver.
package ushs_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REVERT_WAIT,
        ST_CHIRP,
        ST_HOST_WAIT,
        ST_DONE
    } nego_st_t;

    function automatic int max_of2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ushs_tick_timer.sv
// Module: saturating microsecond counter with synchronous clear.
// Assumes tick is a single-cycle strobe; clear takes priority over counting.
module ushs_tick_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);

    // Count ticks, hold at all-ones, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (tick && (cnt != '1))  cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ushs_host_chirp_det.sv
// Module: filters host chirps and counts an alternating K/J sequence.
// Assumes the sequence must open with K; a chirp counts after FILT ticks of
// the expected state. Disabling clears all progress.
module ushs_host_chirp_det
    import ushs_pkg::*;
#(
    parameter int FILT = 3,
    parameter int NCH  = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       us_tick,
    input  logic [1:0] line_state,
    output logic       seen
);

    localparam int FW = $clog2(FILT + 1) + 1;
    localparam int NW = $clog2(NCH + 1) + 1;

    logic          want_k;
    logic [FW-1:0] fcnt;
    logic [NW-1:0] ncnt;
    logic          match;

    // Line equals the chirp polarity currently expected.
    always_comb match = want_k ? (line_state == LS_K) : (line_state == LS_J);

    // Filter and count alternating chirps while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            want_k <= 1'b1;
            fcnt   <= '0;
            ncnt   <= '0;
        end else if (us_tick) begin
            if (!match) begin
                fcnt <= '0;
            end else if (fcnt >= FW'(FILT - 1)) begin
                fcnt   <= '0;
                want_k <= !want_k;
                if (ncnt < NW'(NCH)) ncnt <= ncnt + 1'b1;
            end else begin
                fcnt <= fcnt + 1'b1;
            end
        end
    end

    assign seen = (ncnt >= NW'(NCH));

    // R7: progress cannot pass the required count.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ncnt <= NW'(NCH));

    // R7: a recognised chirp flips the expected polarity.
    a_r7_flip_on_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && (ncnt == $past(ncnt) + 1'b1)) |-> (want_k != $past(want_k)));

endmodule

// File: rtl/ushs_reset_nego.sv
// Module: upstream bus-reset detector and high-speed handshake controller.
// Assumes line_state comes from a full-speed receiver, us_tick pulses once per
// microsecond, and cur_hs/suspended are stable while SE0 is being timed.
module ushs_reset_nego
    import ushs_pkg::*;
#(
    parameter int FILT_US     = 3,
    parameter int FS_WAIT_US  = 10,
    parameter int REVERT_US   = 3000,
    parameter int POSTREV_US  = 500,
    parameter int CHIRP_US    = 2000,
    parameter int FALLBACK_US = 2000,
    parameter int HOST_CHIRPS = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [1:0] line_state,
    input  logic       cur_hs,
    input  logic       suspended,
    output logic       chirp_k,
    output logic       hs_term,
    output logic       reset_pulse,
    output logic       nego_hs,
    output logic       nego_valid
);

    localparam int MAXT = max_of2(max_of2(max_of2(FILT_US, FS_WAIT_US),
                                          max_of2(REVERT_US, POSTREV_US)),
                                  max_of2(CHIRP_US, FALLBACK_US));
    localparam int TW   = $clog2(MAXT + 1) + 1;

    nego_st_t      st, st_nx;
    logic [TW-1:0] tmr;
    logic [TW-1:0] lim_m1;
    logic          tmr_clr;
    logic          hit;
    logic          is_se0;
    logic          seen;
    logic          enter_chirp;
    logic          finish;

    assign is_se0 = (line_state == LS_SE0);

    ushs_tick_timer #(.W(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (us_tick),
        .cnt   (tmr)
    );

    ushs_host_chirp_det #(.FILT(FILT_US), .NCH(HOST_CHIRPS)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (st == ST_HOST_WAIT),
        .us_tick    (us_tick),
        .line_state (line_state),
        .seen       (seen)
    );

    // Pick the time limit that applies to the current state and entry mode.
    always_comb begin
        case (st)
            ST_IDLE:        lim_m1 = suspended ? TW'(FILT_US - 1) :
                                     cur_hs    ? TW'(REVERT_US - 1) : TW'(FS_WAIT_US - 1);
            ST_REVERT_WAIT: lim_m1 = TW'(POSTREV_US - 1);
            ST_CHIRP:       lim_m1 = TW'(CHIRP_US - 1);
            ST_HOST_WAIT:   lim_m1 = TW'(FALLBACK_US - 1);
            default:        lim_m1 = '0;
        endcase
    end

    assign hit = us_tick && (tmr >= lim_m1);

    // Next-state decision for the negotiation sequence.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:
                if (is_se0 && hit)
                    st_nx = (cur_hs && !suspended) ? ST_REVERT_WAIT : ST_CHIRP;
            ST_REVERT_WAIT:
                if (hit) st_nx = is_se0 ? ST_CHIRP : ST_IDLE;
            ST_CHIRP:
                if (hit) st_nx = ST_HOST_WAIT;
            ST_HOST_WAIT:
                if (seen || hit) st_nx = ST_DONE;
            ST_DONE:
                if (!is_se0) st_nx = ST_IDLE;
            default:
                st_nx = ST_IDLE;
        endcase
    end

    // Restart the timer on each state change and whenever idle SE0 breaks.
    assign tmr_clr = (st_nx != st) || ((st == ST_IDLE) && !is_se0);

    assign enter_chirp = (st_nx == ST_CHIRP) && (st != ST_CHIRP);
    assign finish      = (st == ST_HOST_WAIT) && (st_nx == ST_DONE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Registered strobes, negotiated speed and termination select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_pulse <= 1'b0;
            nego_valid  <= 1'b0;
            nego_hs     <= 1'b0;
            hs_term     <= 1'b0;
        end else begin
            reset_pulse <= enter_chirp;
            nego_valid  <= finish;
            if (finish) nego_hs <= seen;
            if ((st_nx == ST_REVERT_WAIT) || (st_nx == ST_CHIRP)) hs_term <= 1'b0;
            else if (finish)                                      hs_term <= seen;
            else if (st == ST_IDLE)                               hs_term <= cur_hs;
        end
    end

    assign chirp_k = (st == ST_CHIRP);

    // Checker state: ticks spent with chirp_k high.
    logic [TW-1:0] chk_chirp_ticks;
    always_ff @(posedge clk) begin
        if (!rst_n || !chirp_k) chk_chirp_ticks <= '0;
        else if (us_tick)       chk_chirp_ticks <= chk_chirp_ticks + 1'b1;
    end

    // R6: the chirp covers exactly the configured number of ticks.
    a_r6_chirp_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_k) |-> (chk_chirp_ticks == TW'(CHIRP_US)));

    // R6: full-speed terminations while chirping.
    a_r6_fs_terms_chirp: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k |-> !hs_term);

    // R9: reset strobe is one cycle and lines up with the chirp start.
    a_r9_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !reset_pulse);
    a_r9_rst_with_chirp: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |-> (chirp_k && $rose(chirp_k)));

    // R7/R8: the result strobe is single-cycle and matches the terminations.
    a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        nego_valid |=> !nego_valid);
    a_r7_valid_terms: assert property (@(posedge clk) disable iff (!rst_n)
        nego_valid |-> (hs_term == nego_hs));

    // R10: without a tick, the timer holds.
    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(us_tick) && !$past(tmr_clr)) |-> $stable(tmr));

endmodule

// File: tb/ushs_reset_nego_tb.sv
// Bench: vector table for SE0 entry thresholds, then directed tests for the
// revert path, host chirp sequences and tick gating.
module ushs_reset_nego_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic [1:0] line_state = 2'b01;
    logic       cur_hs = 1'b0;
    logic       suspended = 1'b0;
    logic       chirp_k, hs_term, reset_pulse, nego_hs, nego_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int n_rst   = 0;
    int n_val   = 0;
    logic v_hs, v_term;

    localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10;

    // {suspended, cur_hs, se0_len[11:0], expect_reset, latency[11:0]}
    localparam logic [26:0] TBL [6] = '{
        {1'b1, 1'b0, 12'd2,    1'b0, 12'd0},
        {1'b1, 1'b0, 12'd40,   1'b1, 12'd3},
        {1'b0, 1'b0, 12'd9,    1'b0, 12'd0},
        {1'b0, 1'b0, 12'd40,   1'b1, 12'd10},
        {1'b1, 1'b1, 12'd40,   1'b1, 12'd3},
        {1'b0, 1'b1, 12'd2999, 1'b0, 12'd0}
    };

    always #10 clk = ~clk;

    ushs_reset_nego u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_tick     (us_tick),
        .line_state  (line_state),
        .cur_hs      (cur_hs),
        .suspended   (suspended),
        .chirp_k     (chirp_k),
        .hs_term     (hs_term),
        .reset_pulse (reset_pulse),
        .nego_hs     (nego_hs),
        .nego_valid  (nego_valid)
    );

    // Strobe monitor, sampling 3 ns after each rising edge.
    always @(posedge clk) begin
        #3;
        if (reset_pulse) n_rst++;
        if (nego_valid) begin
            n_val++;
            v_hs   = nego_hs;
            v_term = hs_term;
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait for chirp start, then measure its length in cycles.
    task automatic chirp_through(output int len, output logic terms_ok);
        int guard = 0;
        terms_ok = 1'b1;
        while (!chirp_k && guard < 6000) begin step(); guard++; end
        len = 0;
        while (chirp_k && len < 6000) begin
            if (hs_term) terms_ok = 1'b0;
            len++;
            step();
        end
    endtask

    task automatic send_chirps(input logic start_k, input int n, input int len);
        for (int c = 0; c < n; c++) begin
            line_state = ((c % 2 == 0) == start_k) ? K : J;
            repeat (len) step();
        end
    endtask

    // Full-speed entry, chirp, then a given host sequence; returns result.
    task automatic fs_handshake(input logic start_k, input int n, input int len,
                                input logic exp_hs, input string req);
        int cl;
        logic tok;
        cur_hs = 1'b0; suspended = 1'b0; line_state = J;
        repeat (5) step();
        n_val = 0;
        line_state = SE0;
        chirp_through(cl, tok);
        send_chirps(start_k, n, len);
        line_state = SE0;
        repeat (2100) step();
        chk(n_val == 1, req, n_val, 1);
        chk(v_hs == exp_hs && v_term == exp_hs, req, int'(v_hs), int'(exp_hs));
        line_state = J;
        repeat (5) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int lat, cl, t;
        logic tok, ck_at;
        string tag;

        // R1: reset state.
        cur_hs = 1'b1;
        repeat (3) step();
        chk(!chirp_k && !hs_term && !reset_pulse && !nego_hs && !nego_valid,
            "R1 reset outputs", int'(chirp_k | hs_term | reset_pulse | nego_hs | nego_valid), 0);
        rst_n = 1'b1;
        step();
        chk(hs_term == 1'b1, "R1 idle follows cur_hs", int'(hs_term), 1);
        cur_hs = 1'b0;
        step();
        step();
        chk(hs_term == 1'b0, "R1 idle follows cur_hs", int'(hs_term), 0);

        // Table: SE0 entry thresholds (R2, R3, R5, R11 encoding).
        for (int r = 0; r < 6; r++) begin
            suspended = TBL[r][26];
            cur_hs    = TBL[r][25];
            line_state = J;
            repeat (5) step();
            n_rst = 0;
            lat = 0;
            ck_at = 1'b0;
            line_state = SE0;
            for (int i = 1; i <= int'(TBL[r][24:13]); i++) begin
                step();
                if (n_rst > 0 && lat == 0) begin lat = i; ck_at = chirp_k; end
            end
            line_state = J;
            repeat (4500) step();
            tag = TBL[r][12] ? (TBL[r][26] ? "R2 suspended entry" : "R3 full-speed entry")
                             : "R5 short SE0 no reset";
            chk(n_rst == int'(TBL[r][12]), tag, n_rst, int'(TBL[r][12]));
            chk(lat == int'(TBL[r][11:0]), tag, lat, int'(TBL[r][11:0]));
            if (TBL[r][12]) chk(ck_at == 1'b1, "R9 chirp with reset", int'(ck_at), 1);
            chk(hs_term == TBL[r][25], "R1 idle terms after row", int'(hs_term), int'(TBL[r][25]));
        end
        suspended = 1'b0;

        // R4: high-speed revert, post-revert sample, chirp, fallback (R6, R8).
        cur_hs = 1'b1; line_state = J;
        repeat (5) step();
        n_rst = 0; n_val = 0;
        line_state = SE0;
        t = 0;
        while (hs_term && t < 4000) begin step(); t++; end
        chk(t == 3000, "R4 revert time", t, 3000);
        while (n_rst == 0 && t < 5000) begin step(); t++; end
        chk(t == 3500, "R4 post-revert wait", t, 3500);
        chk(chirp_k == 1'b1, "R9 chirp with reset", int'(chirp_k), 1);
        chirp_through(cl, tok);
        chk(cl == 2000, "R6 chirp length", cl, 2000);
        chk(tok, "R6 fs terms during chirp", int'(tok), 1);
        t = 0;
        while (n_val == 0 && t < 3000) begin step(); t++; end
        chk(t == 2000, "R8 fallback time", t, 2000);
        chk(v_hs == 1'b0 && v_term == 1'b0, "R8 fallback to full speed", int'(v_hs), 0);
        line_state = J;
        repeat (5) step();

        // R4: line activity mid-wait is ignored; SE0 at the sample point resets.
        line_state = J; repeat (5) step();
        n_rst = 0;
        line_state = SE0; repeat (3100) step();
        line_state = J;   repeat (100) step();
        line_state = SE0; repeat (310) step();
        chk(n_rst == 1, "R4 mid-wait glitch ignored", n_rst, 1);
        line_state = J;
        repeat (4200) step();

        // R4: non-SE0 at the sample point returns to idle without reset.
        n_rst = 0;
        line_state = SE0; repeat (3200) step();
        line_state = J;   repeat (400) step();
        chk(n_rst == 0, "R4 no reset when SE0 gone", n_rst, 0);
        chk(hs_term == 1'b1, "R4 back to high-speed terms", int'(hs_term), 1);

        // R7: full host sequence gives high speed.
        fs_handshake(1'b1, 6, 4, 1'b1, "R7 six chirps high speed");
        // R7: five chirps only, leading J, and short chirps all fall back (R8).
        fs_handshake(1'b1, 5, 4, 1'b0, "R7 five chirps fallback");
        fs_handshake(1'b0, 6, 4, 1'b0, "R7 leading J not counted");
        fs_handshake(1'b1, 12, 2, 1'b0, "R7 short chirps filtered");

        // R10: no tick, no progress.
        cur_hs = 1'b0; line_state = J;
        repeat (5) step();
        n_rst = 0;
        us_tick = 1'b0;
        line_state = SE0;
        repeat (40) step();
        chk(n_rst == 0, "R10 no tick no reset", n_rst, 0);
        us_tick = 1'b1;
        lat = 0;
        for (int i = 1; i <= 20; i++) begin
            step();
            if (n_rst > 0 && lat == 0) lat = i;
        end
        chk(lat == 10, "R10 counts ticks only", lat, 10);
        line_state = J;
        repeat (4200) step();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule